// File: doc/BRIEF.md
# Moving Inversions Memory Self-Test Sequencer

This block drives a synchronous single-port RAM through the moving-inversions test. For each pass it first fills an address window with a base pattern. It then sweeps upward through the window. At each address it reads the word, checks it against the pattern and writes back the complement. It then sweeps downward from the top of the window. At each address it checks for the complement and restores the original pattern. The window bounds and the pattern mode are captured when a start pulse is accepted.

Four pattern modes exist. The first is solid zeros. The second is an 8-bit walking byte copied across the word, run as a 20-pass series. The third is a word drawn from a 32-bit maximal-length LFSR, and that word changes from run to run. The fourth is a one-hot word that rotates left with each address, and its starting bit moves up by one on each pass, so this mode runs one pass per data bit.

The RAM port is a plain request strobe with a write flag. Every read returns a valid strobe one or more cycles later. Only one access is outstanding at any time. Every miscompare is reported on a one-cycle error strobe that carries the address, the expected word and the word read back, and the test keeps going. When the last pass is complete the block raises a done level.

Top module: `mibist_engine`

## Requirements
- R1: While reset is held and after it is released, busy, done, mem_req and err_valid are all low.
- R2: After a start pulse is accepted, each pass begins with writes of the base pattern to every address from lo_addr up to hi_addr. These writes are ascending and one per cycle.
- R3: In the ascending sweep, each address in turn from lo_addr to hi_addr gets a read, then a wait for mem_rvalid, then a write of the complement of that address's pattern. No new request is issued while a read is outstanding.
- R4: The descending sweep runs from hi_addr down to lo_addr. At each address it reads, checks against the complement, and writes the base pattern back.
- R5: Mode code 0 runs a single pass with an all-zeros base pattern.
- R6: Mode code 1 runs 20 passes, numbered p = 0 to 19. Pass p uses a byte with a single one at bit position (p/2) mod 8. On odd p that byte is inverted. The byte is repeated across the word, so word bit k equals byte bit k mod 8.
- R7: Mode code 2 runs a single pass. When start is accepted, the LFSR advances once, and its new state is the pattern (word bit k equals LFSR bit k mod 32). The LFSR uses a right-shift Galois step: when bit 0 is set, the shifted value is XORed with 32'h80200003. The LFSR resets to 1. A seed_load pulse while idle loads a nonzero seed, and a zero seed is ignored. The state carries from one run to the next.
- R8: Mode code 3 runs DW passes. In pass p, the address at offset i = addr - lo_addr has a pattern with only bit (p + i) mod DW set.
- R9: A read whose data differs from the expected word makes err_valid high for one cycle. This happens in the cycle after mem_rvalid, and the strobe carries the address, the expected word and the read word. In that same cycle the write-back to that address is issued, and the test continues.
- R10: After the final descending write, done goes high and busy goes low. Both hold until the next accepted start.
- R11: A start pulse while busy is ignored, and the access sequence continues unchanged.
- R12: A window with lo_addr equal to hi_addr tests that single location with the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted while idle or done |
| mode | input | 2 | Pattern mode code |
| lo_addr | input | AW | Lowest address of the window |
| hi_addr | input | AW | Highest address of the window |
| seed_load | input | 1 | Load seed into the LFSR while idle |
| seed | input | 32 | LFSR seed value |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| err_valid | output | 1 | Miscompare strobe |
| err_addr | output | AW | Failing address |
| err_expect | output | DW | Expected word |
| err_actual | output | DW | Word read back |
| busy | output | 1 | Test in progress |
| done | output | 1 | All passes complete |

## Verification
An error report and the write-back to the failing address fall in the same cycle. The error report comes one cycle after the read data. In that cycle the sequencer is already issuing the complement or restore write to the same location. The bench provokes this with a RAM model that forces selected bits high on one address. A reference model running the same algorithm over the same faulty RAM predicts which reads miscompare. Whenever err_valid is seen, the bench checks that a write to err_addr is on the port in that same cycle, and it checks the report's content against the predicted queue.

// File: rtl/mibist_pkg.sv
package mibist_pkg;

  typedef enum logic [1:0] {
    PM_SOLID = 2'd0,
    PM_WALK8 = 2'd1,
    PM_RAND  = 2'd2,
    PM_ROT   = 2'd3
  } pat_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_UP_RD,
    ST_UP_WAIT,
    ST_UP_WR,
    ST_DN_RD,
    ST_DN_WAIT,
    ST_DN_WR,
    ST_DONE
  } seq_state_e;

  localparam int          WALK8_PASSES = 20;
  localparam logic [31:0] LFSR_TAPS    = 32'h80200003;
  localparam logic [31:0] LFSR_RESET   = 32'h00000001;

  // One right-shift Galois step of the maximal-length generator
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

endpackage

// File: rtl/mibist_lfsr.sv
module mibist_lfsr
  import mibist_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] seed_i,
  input  logic        step_i,
  output logic [31:0] state_o
);

  logic [31:0] state_q;
  logic        seed_ok;

  assign seed_ok = load_i && (seed_i != 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFSR_RESET;
    end else if (seed_ok) begin
      state_q <= seed_i;
    end else if (step_i) begin
      state_q <= lfsr_next(state_q);
    end
  end

  assign state_o = state_q;

  // R7: the generator never falls into the all-zero lock-up state
  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 32'd0);

  // R7: a step moves the state away from its previous value
  a_r7_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (state_q != $past(state_q)));

endmodule

// File: rtl/mibist_pattern.sv
module mibist_pattern
  import mibist_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int PW = 6
) (
  input  pat_mode_e         mode_i,
  input  logic [PW-1:0]     pass_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     lo_i,
  input  logic [31:0]       rand_i,
  output logic [DW-1:0]     pat_o,
  output logic              last_pass_o
);

  localparam int SW = AW + PW + 1;

  function automatic logic [PW-1:0] pass_total(input pat_mode_e m);
    case (m)
      PM_WALK8: return PW'(WALK8_PASSES);
      PM_ROT:   return PW'(DW);
      default:  return PW'(1);
    endcase
  endfunction

  function automatic logic [DW-1:0] walk_word(input logic [PW-1:0] p);
    logic [7:0]    b;
    logic [DW-1:0] w;
    b = 8'h01 << p[3:1];
    if (p[0]) b = ~b;
    for (int k = 0; k < DW; k++) w[k] = b[k % 8];
    return w;
  endfunction

  function automatic logic [DW-1:0] rand_word(input logic [31:0] r);
    logic [DW-1:0] w;
    for (int k = 0; k < DW; k++) w[k] = r[k % 32];
    return w;
  endfunction

  function automatic logic [DW-1:0] rot_word(input logic [PW-1:0] p,
                                             input logic [AW-1:0] off);
    logic [SW-1:0] s;
    s = SW'(p) + SW'(off);
    s = s % SW'(DW);
    return {{(DW-1){1'b0}}, 1'b1} << s;
  endfunction

  logic [AW-1:0] offset;
  assign offset = addr_i - lo_i;

  always_comb begin
    case (mode_i)
      PM_WALK8: pat_o = walk_word(pass_i);
      PM_RAND:  pat_o = rand_word(rand_i);
      PM_ROT:   pat_o = rot_word(pass_i, offset);
      default:  pat_o = '0;
    endcase
  end

  assign last_pass_o = (pass_i == PW'(pass_total(mode_i) - PW'(1)));

  // R8: the rotating pattern is always one-hot
  always_comb begin
    if (mode_i == PM_ROT) begin
      a_r8_onehot: assert ($countones(pat_o) == 1);
    end
  end

endmodule

// File: rtl/mibist_seq.sv
module mibist_seq
  import mibist_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  pat_mode_e     mode_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [DW-1:0] pat_i,
  input  logic          last_pass_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output pat_mode_e     mode_q_o,
  output logic [AW-1:0] lo_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic [PW-1:0] pass_q_o,
  output logic          lfsr_step_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          err_valid_o,
  output logic [AW-1:0] err_addr_o,
  output logic [DW-1:0] err_expect_o,
  output logic [DW-1:0] err_actual_o,
  output logic          busy_o,
  output logic          done_o
);

  seq_state_e    st;
  pat_mode_e     mode_q;
  logic [AW-1:0] lo_q, hi_q, addr_q;
  logic [PW-1:0] pass_q;
  logic          err_valid_q;
  logic [AW-1:0] err_addr_q;
  logic [DW-1:0] err_exp_q, err_act_q;

  // named internal events
  logic idle_like, accept;
  logic fill_wr, up_rd, up_wait, up_wr, dn_rd, dn_wait, dn_wr;
  logic at_hi, at_lo, rd_done, miscompare;
  logic [DW-1:0] chk_expect;

  assign idle_like  = (st == ST_IDLE) || (st == ST_DONE);
  assign accept     = start_i && idle_like;
  assign fill_wr    = (st == ST_FILL);
  assign up_rd      = (st == ST_UP_RD);
  assign up_wait    = (st == ST_UP_WAIT);
  assign up_wr      = (st == ST_UP_WR);
  assign dn_rd      = (st == ST_DN_RD);
  assign dn_wait    = (st == ST_DN_WAIT);
  assign dn_wr      = (st == ST_DN_WR);
  assign at_hi      = (addr_q == hi_q);
  assign at_lo      = (addr_q == lo_q);
  assign chk_expect = up_wait ? pat_i : ~pat_i;
  assign rd_done    = (up_wait || dn_wait) && mem_rvalid_i;
  assign miscompare = rd_done && (mem_rdata_i != chk_expect);

  assign lfsr_step_o = accept && (mode_i == PM_RAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      mode_q      <= PM_SOLID;
      lo_q        <= '0;
      hi_q        <= '0;
      addr_q      <= '0;
      pass_q      <= '0;
      err_valid_q <= 1'b0;
      err_addr_q  <= '0;
      err_exp_q   <= '0;
      err_act_q   <= '0;
    end else begin
      err_valid_q <= miscompare;
      if (miscompare) begin
        err_addr_q <= addr_q;
        err_exp_q  <= chk_expect;
        err_act_q  <= mem_rdata_i;
      end
      case (st)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            mode_q <= mode_i;
            lo_q   <= lo_i;
            hi_q   <= hi_i;
            addr_q <= lo_i;
            pass_q <= '0;
            st     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (at_hi) begin
            addr_q <= lo_q;
            st     <= ST_UP_RD;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_UP_RD:   st <= ST_UP_WAIT;
        ST_UP_WAIT: if (mem_rvalid_i) st <= ST_UP_WR;
        ST_UP_WR: begin
          if (at_hi) begin
            st <= ST_DN_RD;
          end else begin
            addr_q <= addr_q + 1'b1;
            st     <= ST_UP_RD;
          end
        end
        ST_DN_RD:   st <= ST_DN_WAIT;
        ST_DN_WAIT: if (mem_rvalid_i) st <= ST_DN_WR;
        ST_DN_WR: begin
          if (!at_lo) begin
            addr_q <= addr_q - 1'b1;
            st     <= ST_DN_RD;
          end else if (last_pass_i) begin
            st <= ST_DONE;
          end else begin
            pass_q <= pass_q + 1'b1;
            st     <= ST_FILL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_wdata_o = '0;
    if (fill_wr || dn_wr) mem_wdata_o = pat_i;
    else if (up_wr)       mem_wdata_o = ~pat_i;
  end

  assign mem_req_o    = fill_wr || up_rd || up_wr || dn_rd || dn_wr;
  assign mem_we_o     = fill_wr || up_wr || dn_wr;
  assign mem_addr_o   = addr_q;
  assign mode_q_o     = mode_q;
  assign lo_q_o       = lo_q;
  assign addr_q_o     = addr_q;
  assign pass_q_o     = pass_q;
  assign err_valid_o  = err_valid_q;
  assign err_addr_o   = err_addr_q;
  assign err_expect_o = err_exp_q;
  assign err_actual_o = err_act_q;
  assign busy_o       = !idle_like;
  assign done_o       = (st == ST_DONE);

  // R3: a read is never followed directly by another request
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

  // R2: consecutive fill writes climb by one address
  a_r2_fill_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_wr && $past(fill_wr)) |-> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R4: a descending read after a restore write steps down by one
  a_r4_down_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd && $past(dn_wr)) |-> (mem_addr_o == AW'($past(mem_addr_o) - 1'b1)));

  // R9: an error report follows returned read data and meets the write-back
  a_r9_err_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o |-> ($past(mem_rvalid_i) && mem_req_o && mem_we_o &&
                     (mem_addr_o == err_addr_o)));

  // R10: done is quiet on the RAM port
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !mem_req_o));

  // R11: a start during a run does not end the run
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !dn_wr) |=> busy_o);

endmodule

// File: rtl/mibist_engine.sv
module mibist_engine
  import mibist_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic          seed_load,
  input  logic [31:0]   seed,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_expect,
  output logic [DW-1:0] err_actual,
  output logic          busy,
  output logic          done
);

  localparam int MAXP = (DW > WALK8_PASSES) ? DW : WALK8_PASSES;
  localparam int PW   = $clog2(MAXP + 1);

  pat_mode_e     mode_q;
  logic [AW-1:0] lo_q, addr_q;
  logic [PW-1:0] pass_q;
  logic [DW-1:0] pat;
  logic          last_pass, lfsr_step;
  logic [31:0]   lfsr_state;

  mibist_lfsr u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (seed_load && !busy),
    .seed_i  (seed),
    .step_i  (lfsr_step),
    .state_o (lfsr_state)
  );

  mibist_pattern #(.AW(AW), .DW(DW), .PW(PW)) u_pattern (
    .mode_i      (mode_q),
    .pass_i      (pass_q),
    .addr_i      (addr_q),
    .lo_i        (lo_q),
    .rand_i      (lfsr_state),
    .pat_o       (pat),
    .last_pass_o (last_pass)
  );

  mibist_seq #(.AW(AW), .DW(DW), .PW(PW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .mode_i       (pat_mode_e'(mode)),
    .lo_i         (lo_addr),
    .hi_i         (hi_addr),
    .pat_i        (pat),
    .last_pass_i  (last_pass),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .mode_q_o     (mode_q),
    .lo_q_o       (lo_q),
    .addr_q_o     (addr_q),
    .pass_q_o     (pass_q),
    .lfsr_step_o  (lfsr_step),
    .mem_req_o    (mem_req),
    .mem_we_o     (mem_we),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .err_valid_o  (err_valid),
    .err_addr_o   (err_addr),
    .err_expect_o (err_expect),
    .err_actual_o (err_actual),
    .busy_o       (busy),
    .done_o       (done)
  );

  // R1: outputs stay quiet through and right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !err_valid));

endmodule

// File: tb/test_mibist_engine.sv
module test_mibist_engine;

  localparam int AW = 8;
  localparam int DW = 32;

  typedef struct { logic we; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;
  typedef struct { logic [AW-1:0] a; logic [DW-1:0] e; logic [DW-1:0] g; } er_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode_in = 2'd0;
  logic [AW-1:0] lo_in = '0, hi_in = '0;
  logic          seed_load = 1'b0;
  logic [31:0]   seed = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          err_valid, busy, done;
  logic [AW-1:0] err_addr;
  logic [DW-1:0] err_expect, err_actual;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "";

  op_t exp_ops[$];
  er_t exp_errs[$];
  logic [DW-1:0] ram   [0:255];
  logic [DW-1:0] ref_m [0:255];
  logic [AW-1:0] fault_addr = '0;
  logic [DW-1:0] fault_mask = '0;
  logic [31:0]   ref_lfsr = 32'h1;

  always #2 clk = ~clk;

  mibist_engine #(.AW(AW), .DW(DW)) i_mibist_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_in),
    .lo_addr(lo_in), .hi_addr(hi_in), .seed_load(seed_load), .seed(seed),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .err_valid(err_valid), .err_addr(err_addr), .err_expect(err_expect),
    .err_actual(err_actual), .busy(busy), .done(done)
  );

  // RAM model with one address whose masked bits are stuck high
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req) begin
      if (mem_we) ram[mem_addr] <= (mem_addr == fault_addr) ? (mem_wdata | fault_mask) : mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= ram[mem_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s %s actual=%h expected=%h", req, cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step_model(input logic [31:0] s);
    logic fb;
    fb = s[0];
    s = {1'b0, s[31:1]};
    if (fb) s = s ^ 32'h80200003;
    return s;
  endfunction

  function automatic logic [DW-1:0] model_pat(input int m, input int p, input int i,
                                              input logic [31:0] rw);
    logic [DW-1:0] w;
    logic [7:0] bt;
    w = '0;
    case (m)
      1: begin
        bt = '0;
        bt[(p / 2) % 8] = 1'b1;
        if (p % 2 == 1) bt = ~bt;
        for (int k = 0; k < DW; k++) w[k] = bt[k % 8];
      end
      2: for (int k = 0; k < DW; k++) w[k] = rw[k % 32];
      3: w[(p + i) % DW] = 1'b1;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [DW-1:0] stored(input int a, input logic [DW-1:0] w);
    return (AW'(a) == fault_addr) ? (w | fault_mask) : w;
  endfunction

  task automatic push_rd_chk(input int a, input logic [DW-1:0] e);
    exp_ops.push_back('{1'b0, AW'(a), '0});
    if (ref_m[a] != e) exp_errs.push_back('{AW'(a), e, ref_m[a]});
  endtask

  // reference run of the whole algorithm over the faulty RAM
  task automatic build(input int m, input int lo, input int hi, input logic [31:0] rw);
    int np;
    logic [DW-1:0] w;
    np = (m == 1) ? 20 : (m == 3) ? DW : 1;
    for (int p = 0; p < np; p++) begin
      for (int a = lo; a <= hi; a++) begin
        w = model_pat(m, p, a - lo, rw);
        exp_ops.push_back('{1'b1, AW'(a), w});
        ref_m[a] = stored(a, w);
      end
      for (int a = lo; a <= hi; a++) begin
        w = model_pat(m, p, a - lo, rw);
        push_rd_chk(a, w);
        exp_ops.push_back('{1'b1, AW'(a), ~w});
        ref_m[a] = stored(a, ~w);
      end
      for (int a = hi; a >= lo; a--) begin
        w = model_pat(m, p, a - lo, rw);
        push_rd_chk(a, ~w);
        exp_ops.push_back('{1'b1, AW'(a), w});
        ref_m[a] = stored(a, w);
      end
    end
  endtask

  // monitor: pops the scoreboard as the design produces traffic and reports
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_ops.size() == 0) begin
        chk(1'b0, "R2", "unexpected access at", 64'(mem_addr), 64'hFFFF);
      end else begin
        op_t o;
        o = exp_ops.pop_front();
        chk(mem_we == o.we && mem_addr == o.a, "R3", "access type/address (R2 R4)",
            {55'd0, mem_we, mem_addr}, {55'd0, o.we, o.a});
        if (o.we) chk(mem_wdata == o.d, "R4", "write data (R5 R6 R7 R8)",
                      64'(mem_wdata), 64'(o.d));
      end
    end
    if (rst_n && err_valid) begin
      chk(mem_req && mem_we && mem_addr == err_addr, "R9", "write-back meets report",
          64'(mem_addr), 64'(err_addr));
      if (exp_errs.size() == 0) begin
        chk(1'b0, "R9", "unexpected error at", 64'(err_addr), 64'hFFFF);
      end else begin
        er_t e;
        e = exp_errs.pop_front();
        chk(err_addr == e.a && err_expect == e.e && err_actual == e.g, "R9",
            "error report addr/expect", {err_addr, err_expect}, {e.a, e.e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk);
    seed_load = 1'b1;
    seed = s;
    @(negedge clk);
    seed_load = 1'b0;
    if (s != 32'd0) ref_lfsr = s;
  endtask

  task automatic run(input int m, input int lo, input int hi, input bit poke, input string tag);
    logic [31:0] rw;
    int n;
    cur_tag = tag;
    rw = '0;
    if (m == 2) begin
      ref_lfsr = step_model(ref_lfsr);
      rw = ref_lfsr;
    end
    build(m, lo, hi, rw);
    @(negedge clk);
    start = 1'b1;
    mode_in = 2'(m);
    lo_in = AW'(lo);
    hi_in = AW'(hi);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1;          // R11: start while busy must be ignored
      mode_in = 2'd3;
      lo_in = '0;
      hi_in = 8'd200;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done && !busy, "R10", "done high, busy low", {busy, done}, 2'b01);
    chk(exp_ops.size() == 0, "R10", "accesses left over", 64'(exp_ops.size()), 64'd0);
    chk(exp_errs.size() == 0, "R9", "errors left over", 64'(exp_errs.size()), 64'd0);
    repeat (3) @(negedge clk);
    chk(done && !busy && !mem_req, "R10", "done held", {mem_req, busy, done}, 3'b001);
    exp_ops.delete();
    exp_errs.delete();
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      ram[a] = '0;
      ref_m[a] = '0;
    end
    repeat (3) @(negedge clk);
    cur_tag = "reset";
    chk(!busy && !done && !mem_req && !err_valid, "R1", "outputs in reset",
        {err_valid, mem_req, busy, done}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !err_valid, "R1", "outputs after reset",
        {err_valid, mem_req, busy, done}, 4'b0);

    fault_addr = 8'd250; fault_mask = '0;
    run(0, 4, 11, 1'b0, "R5 solid clean");
    fault_addr = 8'd7;   fault_mask = 32'h0000_0020;
    run(0, 4, 11, 1'b0, "R9 solid stuck bit");
    fault_addr = 8'd2;   fault_mask = 32'h0000_0100;
    run(1, 0, 3, 1'b0, "R6 walk8");
    fault_addr = 8'd250; fault_mask = '0;
    load_seed(32'h0000_ACE1);
    run(2, 20, 27, 1'b0, "R7 random seeded");
    load_seed(32'h0);
    fault_addr = 8'd21;  fault_mask = 32'h8000_0000;
    run(2, 20, 27, 1'b0, "R7 random next run");
    fault_addr = 8'd12;  fault_mask = 32'h0000_0008;
    run(3, 10, 14, 1'b0, "R8 rotate");
    fault_addr = 8'd9;   fault_mask = 32'h0001_0000;
    run(0, 9, 9, 1'b0, "R12 single location");
    fault_addr = 8'd250; fault_mask = '0;
    run(0, 30, 37, 1'b1, "R11 start while busy");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule